// File: doc/BRIEF.md
# Task Execution-Time Watchdog Monitor

This block supervises a processor that time-shares several tasks. The operating system tells the monitor when a task starts, when the scheduler swaps one task out for another, and when a task finishes. The monitor counts clock cycles for the task in the foreground. On every swap it stores that count in a per-task context table and restores the count of the incoming task, so the slices of one task add up to a single total. Each task has a lower and an upper cycle bound. A task that runs past its upper bound, or finishes before its lower bound, raises a latched error interrupt. A task that is active but is not scheduled for a whole sweep period is flagged as starved.

The host reaches the monitor through two 16-bit registers. Writes to the command register are decoded as operations. The data register carries bound values inward, 16 bits at a time, and carries results outward: the error cause, the live count and a liveness signature. The register port has no back-pressure. Every write is accepted on the clock edge where it is presented, and the data register can be read at any time.

Command word layout: bits [15:12] hold the opcode, bit [8] is a selector and bits [3:0] hold a task number. Opcodes: 1 wipe table, 2 zero saved counts, 3 ping, 4 load bound, 5 start, 6 switch, 7 end, 8 acknowledge, 9 read cause, 10 read live count.

Top module: `task_time_guard`

## Requirements
- R1: After reset `err_irq` is low and `host_rdata` is 0.
- R2: A data write (`host_sel`=1) is readable on `host_rdata` after that edge. Data writes fill a 32-bit staging value low half first, then high half, and any command write restarts that order. Command 4 copies the staged value into the lower bound (bit 8 = 0) or the upper bound (bit 8 = 1) of the task named in bits [3:0].
- R3: Command 5 (start) sets the live counter to 0 on its edge. The counter then adds 1 on every later edge while a task runs. Command 10 copies the counter value held before its edge into the data register: the low half when bit 8 = 0, the high half when bit 8 = 1.
- R4: Command 6 (switch) stores the live count in the entry of the outgoing task. It loads the counter with the saved count of the named task, which becomes the running task.
- R5: While a task runs, a count above its upper bound latches `err_irq` one edge later, with cause code 2.
- R6: Command 7 (end) with a count below the running task's lower bound latches `err_irq` on that edge, with cause code 1. A count at or above the lower bound raises nothing.
- R7: Start and switch mark the named task as active and as recently scheduled. Every sweep period clears the recently-scheduled marks of all tasks except the running one. If an active task that is not running still has its mark cleared at a sweep, `err_irq` latches with cause code 3.
- R8: `err_irq` and its cause stay latched until command 8, which clears both. Command 9 puts the cause in bits [7:4] and the task number in bits [3:0] of the data register. The other bits read as 0.
- R9: Command 3 (ping) loads 16'hA5C3 into the data register on its edge.
- R10: Command 2 sets the saved count of every entry to 0 and leaves the live counter unchanged.
- R11: Command 1 resets every lower bound to 0 and every upper bound to all ones. It marks all tasks inactive and stops counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 1 | 0 = command register, 1 = data register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Data register contents |
| err_irq | output | 1 | Latched error interrupt |

## Verification
The assertions check four behaviours on every cycle: the counter steps by one while running, it returns to zero after a start, the interrupt holds until acknowledge and drops right after it, and a count above the upper bound is latched on the next edge. They also check that ping yields the signature and that the table is wiped correctly. Only the bench scenarios show that counts survive a round of switches. The same applies to the zeroing of saved counts, the early-end check against the lower bound, the starvation of a task that is swapped out, and the cause words read back through the data register.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_CLR_ALL = 4'd1,
    OP_CLR_CNT = 4'd2,
    OP_PING    = 4'd3,
    OP_LOAD    = 4'd4,
    OP_START   = 4'd5,
    OP_SWITCH  = 4'd6,
    OP_END     = 4'd7,
    OP_ACK     = 4'd8,
    OP_CAUSE   = 4'd9,
    OP_RDCNT   = 4'd10
  } op_e;

  typedef enum logic [3:0] {
    CAUSE_NONE   = 4'd0,
    CAUSE_EARLY  = 4'd1,
    CAUSE_LATE   = 4'd2,
    CAUSE_STARVE = 4'd3
  } cause_e;

  localparam logic [15:0] ALIVE_SIG = 16'hA5C3;
endpackage

// File: rtl/tg_cycle_counter.sv
module tg_cycle_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         pre,
  input  logic [W-1:0] pre_val,
  input  logic         run,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (pre)                cnt_q <= pre_val;
    else if (run && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !pre && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/tg_ctx_table.sv
module tg_ctx_table #(
  parameter int TASKS = 16,
  parameter int W     = 32,
  localparam int IW   = $clog2(TASKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             clr_cnt,
  input  logic             act_en,
  input  logic [IW-1:0]    act_id,
  input  logic             ret_en,
  input  logic [IW-1:0]    ret_id,
  input  logic             save_en,
  input  logic [IW-1:0]    save_id,
  input  logic [W-1:0]     save_val,
  input  logic             load_en,
  input  logic             load_hi,
  input  logic [IW-1:0]    load_id,
  input  logic [W-1:0]     load_val,
  input  logic             sweep,
  input  logic             keep_en,
  input  logic [IW-1:0]    keep_id,
  input  logic [IW-1:0]    in_id,
  output logic [W-1:0]     in_saved,
  input  logic [IW-1:0]    cur_id,
  output logic [W-1:0]     cur_lo,
  output logic [W-1:0]     cur_hi,
  output logic [TASKS-1:0] valid_o,
  output logic [TASKS-1:0] idle_o
);
  logic [W-1:0]     saved_q [TASKS];
  logic [W-1:0]     lo_q    [TASKS];
  logic [W-1:0]     hi_q    [TASKS];
  logic [TASKS-1:0] valid_q;
  logic [TASKS-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr_all) begin
      for (int i = 0; i < TASKS; i++) begin
        saved_q[i] <= '0;
        lo_q[i]    <= '0;
        hi_q[i]    <= '1;
      end
      valid_q <= '0;
      idle_q  <= '0;
    end else begin
      if (sweep) begin
        idle_q <= '0;
        if (keep_en) idle_q[keep_id] <= 1'b1;
      end
      if (clr_cnt)
        for (int i = 0; i < TASKS; i++) saved_q[i] <= '0;
      if (save_en) saved_q[save_id] <= save_val;
      if (ret_en) begin
        valid_q[ret_id] <= 1'b0;
        saved_q[ret_id] <= '0;
      end
      if (act_en) begin
        valid_q[act_id] <= 1'b1;
        idle_q[act_id]  <= 1'b1;
      end
      if (load_en) begin
        if (load_hi) hi_q[load_id] <= load_val;
        else         lo_q[load_id] <= load_val;
      end
    end
  end

  assign in_saved = saved_q[in_id];
  assign cur_lo   = lo_q[cur_id];
  assign cur_hi   = hi_q[cur_id];
  assign valid_o  = valid_q;
  assign idle_o   = idle_q;

  // R7
  act_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && !clr_all) |=> valid_q[$past(act_id)] && idle_q[$past(act_id)]);
  // R11
  wipe_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (hi_q[0] == '1) && (lo_q[0] == '0) && (valid_q == '0));
endmodule

// File: rtl/tg_sweep_timer.sv
module tg_sweep_timer #(
  parameter int PERIOD = 4096,
  localparam int CW    = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R7
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/task_time_guard.sv
module task_time_guard #(
  parameter int TASKS        = 16,
  parameter int REG_W        = 16,
  parameter int SWEEP_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_sel,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  output logic             err_irq
);
  import tg_pkg::*;

  localparam int CNT_W = 2 * REG_W;
  localparam int IW    = $clog2(TASKS);

  logic cmd_wr, dat_wr;
  op_e  op;
  logic [IW-1:0] arg_id;
  logic arg_sel;
  logic unused_bits;

  assign cmd_wr  = host_wr && !host_sel;
  assign dat_wr  = host_wr && host_sel;
  assign op      = op_e'(host_wdata[REG_W-1 -: 4]);
  assign arg_id  = host_wdata[IW-1:0];
  assign arg_sel = host_wdata[8];
  assign unused_bits = ^{host_wdata[REG_W-5:9], host_wdata[7:IW]};

  logic is_clr_all, is_clr_cnt, is_ping, is_load, is_start;
  logic is_switch, is_end, is_ack, is_cause, is_rdcnt;
  assign is_clr_all = cmd_wr && op == OP_CLR_ALL;
  assign is_clr_cnt = cmd_wr && op == OP_CLR_CNT;
  assign is_ping    = cmd_wr && op == OP_PING;
  assign is_load    = cmd_wr && op == OP_LOAD;
  assign is_start   = cmd_wr && op == OP_START;
  assign is_switch  = cmd_wr && op == OP_SWITCH;
  assign is_end     = cmd_wr && op == OP_END;
  assign is_ack     = cmd_wr && op == OP_ACK;
  assign is_cause   = cmd_wr && op == OP_CAUSE;
  assign is_rdcnt   = cmd_wr && op == OP_RDCNT;

  logic             running_q;
  logic [IW-1:0]    cur_q;
  logic [REG_W-1:0] data_q, stage_lo_q, stage_hi_q;
  logic             phase_q;
  logic             irq_q;
  cause_e           cause_q;
  logic [IW-1:0]    etid_q;

  logic [CNT_W-1:0] cnt, in_saved, cur_lo, cur_hi;
  logic [TASKS-1:0] valid, idle;
  logic             tick;

  tg_cycle_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(is_start), .pre(is_switch),
    .pre_val(in_saved), .run(running_q), .cnt(cnt)
  );

  tg_ctx_table #(.TASKS(TASKS), .W(CNT_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .clr_all(is_clr_all), .clr_cnt(is_clr_cnt),
    .act_en(is_start || is_switch), .act_id(arg_id),
    .ret_en(is_end && running_q), .ret_id(cur_q),
    .save_en(is_switch && running_q), .save_id(cur_q), .save_val(cnt),
    .load_en(is_load), .load_hi(arg_sel), .load_id(arg_id),
    .load_val({stage_hi_q, stage_lo_q}),
    .sweep(tick), .keep_en(running_q), .keep_id(cur_q),
    .in_id(arg_id), .in_saved(in_saved),
    .cur_id(cur_q), .cur_lo(cur_lo), .cur_hi(cur_hi),
    .valid_o(valid), .idle_o(idle)
  );

  tg_sweep_timer #(.PERIOD(SWEEP_CYCLES)) u_sweep (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  logic [TASKS-1:0] starve_vec;
  logic [IW-1:0]    starve_id;
  logic             early, late, starve;
  logic [REG_W-1:0] cause_word;

  always_comb begin
    starve_vec = valid & ~idle;
    if (running_q) starve_vec[cur_q] = 1'b0;
    starve_id = '0;
    for (int i = TASKS - 1; i >= 0; i--)
      if (starve_vec[i]) starve_id = IW'(i);
    cause_word = '0;
    cause_word[7:4]    = cause_q;
    cause_word[IW-1:0] = etid_q;
  end

  assign early  = is_end && running_q && (cnt < cur_lo);
  assign late   = running_q && (cnt > cur_hi);
  assign starve = tick && (starve_vec != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q  <= 1'b0;
      cur_q      <= '0;
      data_q     <= '0;
      stage_lo_q <= '0;
      stage_hi_q <= '0;
      phase_q    <= 1'b0;
      irq_q      <= 1'b0;
      cause_q    <= CAUSE_NONE;
      etid_q     <= '0;
    end else begin
      if (is_start || is_switch) begin
        running_q <= 1'b1;
        cur_q     <= arg_id;
      end else if (is_end || is_clr_all) begin
        running_q <= 1'b0;
      end

      if (dat_wr) begin
        data_q  <= host_wdata;
        phase_q <= !phase_q;
        if (phase_q) stage_hi_q <= host_wdata;
        else         stage_lo_q <= host_wdata;
      end else if (cmd_wr) begin
        phase_q <= 1'b0;
      end

      if (is_ping)  data_q <= ALIVE_SIG;
      if (is_cause) data_q <= cause_word;
      if (is_rdcnt) data_q <= arg_sel ? cnt[CNT_W-1:REG_W] : cnt[REG_W-1:0];

      if (is_ack) begin
        irq_q   <= 1'b0;
        cause_q <= CAUSE_NONE;
        etid_q  <= '0;
      end else if (!irq_q) begin
        if (early) begin
          irq_q <= 1'b1; cause_q <= CAUSE_EARLY; etid_q <= cur_q;
        end else if (late) begin
          irq_q <= 1'b1; cause_q <= CAUSE_LATE; etid_q <= cur_q;
        end else if (starve) begin
          irq_q <= 1'b1; cause_q <= CAUSE_STARVE; etid_q <= starve_id;
        end
      end
    end
  end

  assign host_rdata = data_q;
  assign err_irq    = irq_q;

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !is_ack) |=> irq_q);
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ack |=> !irq_q);
  // R9
  ping_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ping |=> host_rdata == ALIVE_SIG);
  // R5
  late_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && (cnt > cur_hi) && !is_ack) |=> irq_q);
endmodule

// File: tb/tb_task_time_guard.sv
module tb_task_time_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        err_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  task_time_guard #(.SWEEP_CYCLES(200)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .err_irq(err_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(logic [3:0] op, logic sel, logic [3:0] id);
    return {op, 3'b000, sel, 4'b0000, id};
  endfunction

  task automatic put(logic sel, logic [15:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
  endtask

  task automatic cmd(logic [3:0] op, logic sel, logic [3:0] id);
    put(1'b0, cw(op, sel, id));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_bound(logic hi, logic [3:0] id, logic [31:0] v);
    put(1'b1, v[15:0]);
    put(1'b1, v[31:16]);
    cmd(4'd4, hi, id);
  endtask

  task automatic fresh();
    cmd(4'd1, 1'b0, 4'd0);
    cmd(4'd8, 1'b0, 4'd0);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", 32'(err_irq), 32'd0);
    chk("R1 data after reset", 32'(host_rdata), 32'd0);
  endtask

  task automatic t_data_ping();
    fresh();
    put(1'b1, 16'h1234);
    chk("R2 data readback", 32'(host_rdata), 32'h1234);
    cmd(4'd3, 1'b0, 4'd0);
    chk("R9 ping signature", 32'(host_rdata), 32'hA5C3);
  endtask

  task automatic t_count();
    fresh();
    cmd(4'd5, 1'b0, 4'd5);
    idle(6);
    cmd(4'd10, 1'b0, 4'd0);
    chk("R3 live count low", 32'(host_rdata), 32'd6);
    cmd(4'd10, 1'b1, 4'd0);
    chk("R3 live count high", 32'(host_rdata), 32'd0);
    fresh();
  endtask

  task automatic t_switch();
    fresh();
    cmd(4'd5, 1'b0, 4'd1);
    idle(9);
    cmd(4'd6, 1'b0, 4'd2);
    idle(4);
    cmd(4'd6, 1'b0, 4'd1);
    cmd(4'd10, 1'b0, 4'd0);
    chk("R4 restored count of task 1", 32'(host_rdata), 32'd9);
    cmd(4'd6, 1'b0, 4'd2);
    cmd(4'd10, 1'b0, 4'd0);
    chk("R4 restored count of task 2", 32'(host_rdata), 32'd4);
    chk("R4 no error during switches", 32'(err_irq), 32'd0);
    fresh();
  endtask

  task automatic t_clr_cnt();
    fresh();
    cmd(4'd5, 1'b0, 4'd1);
    idle(5);
    cmd(4'd6, 1'b0, 4'd2);
    cmd(4'd2, 1'b0, 4'd0);
    cmd(4'd6, 1'b0, 4'd1);
    cmd(4'd10, 1'b0, 4'd0);
    chk("R10 saved count zeroed", 32'(host_rdata), 32'd0);
    fresh();
  endtask

  task automatic t_late();
    fresh();
    load_bound(1'b1, 4'd3, 32'd20);
    cmd(4'd5, 1'b0, 4'd3);
    idle(20);
    chk("R5 no error at bound", 32'(err_irq), 32'd0);
    idle(1);
    chk("R5 no error before latch edge", 32'(err_irq), 32'd0);
    idle(1);
    chk("R5 error one edge after overrun", 32'(err_irq), 32'd1);
    cmd(4'd7, 1'b0, 4'd0);
    idle(3);
    chk("R8 error stays latched", 32'(err_irq), 32'd1);
    cmd(4'd9, 1'b0, 4'd0);
    chk("R8 cause word late task 3", 32'(host_rdata), 32'h0023);
    cmd(4'd8, 1'b0, 4'd0);
    chk("R8 ack clears irq", 32'(err_irq), 32'd0);
    cmd(4'd9, 1'b0, 4'd0);
    chk("R8 cause cleared", 32'(host_rdata), 32'h0000);
  endtask

  task automatic t_early();
    fresh();
    load_bound(1'b0, 4'd4, 32'd50);
    cmd(4'd5, 1'b0, 4'd4);
    idle(5);
    cmd(4'd7, 1'b0, 4'd0);
    chk("R6 early end raises irq", 32'(err_irq), 32'd1);
    cmd(4'd9, 1'b0, 4'd0);
    chk("R6 cause word early task 4", 32'(host_rdata), 32'h0014);
    cmd(4'd8, 1'b0, 4'd0);
    load_bound(1'b0, 4'd4, 32'd5);
    cmd(4'd5, 1'b0, 4'd4);
    idle(10);
    cmd(4'd7, 1'b0, 4'd0);
    chk("R6 end above lower bound is clean", 32'(err_irq), 32'd0);
  endtask

  task automatic t_wipe();
    fresh();
    load_bound(1'b1, 4'd3, 32'd20);
    load_bound(1'b0, 4'd4, 32'd50);
    cmd(4'd1, 1'b0, 4'd0);
    cmd(4'd5, 1'b0, 4'd3);
    idle(30);
    chk("R11 upper bound back to all ones", 32'(err_irq), 32'd0);
    cmd(4'd5, 1'b0, 4'd4);
    cmd(4'd7, 1'b0, 4'd0);
    chk("R11 lower bound back to zero", 32'(err_irq), 32'd0);
  endtask

  task automatic t_starve();
    fresh();
    cmd(4'd5, 1'b0, 4'd1);
    cmd(4'd6, 1'b0, 4'd2);
    idle(450);
    chk("R7 starvation raises irq", 32'(err_irq), 32'd1);
    cmd(4'd9, 1'b0, 4'd0);
    chk("R7 cause word starve task 1", 32'(host_rdata), 32'h0031);
    fresh();
    chk("R8 cleared after wipe and ack", 32'(err_irq), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_ping();
    t_count();
    t_switch();
    t_clr_cnt();
    t_late();
    t_early();
    t_wipe();
    t_starve();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule